// File: doc/BRIEF.md
# Deep-Sleep Wake and Pin-Retention Controller

This controller sequences the deepest low-power mode of a small microcontroller. When the CPU issues a stop request while the deep-sleep mode bit is set, the controller freezes every pin control signal in a bank of retention registers. The three signals per pin are output value, direction and pull enable. It then tells the core domain to power down. The pins keep their frozen states while the core is off.

The block leaves sleep when the wake pin is driven low, or when the real-time counter raises its event while that wake source is enabled. The wake pin is resynchronised by two flops on the always-on clock. The controller then runs three timed phases in a fixed order: regulator recovery, clock-source startup and reset processing. Each phase length is counted in always-on clock cycles.

During reset processing a per-register reset vector reaches every module register except those marked as surviving in a mask. While the low-voltage trip input is high, reset processing does not advance. After reset the power-down flag is set and instruction fetch is allowed. The pins stay frozen, and the flag stays set, until software writes 1 to the acknowledge bit.

Top module: `dsleep_ctrl`

## Requirements
- R1: In phase run, `stop_req` high with `deep_sel` high moves the controller to phase sleeping on the next clock, and `core_pwr_dn` is high while sleeping. `stop_req` with `deep_sel` low has no effect.
- R2: In the cycle of entry, the pin outputs capture the live pin controls `{pull, dir, out}`. They then hold those values, whatever the live inputs do, until the acknowledge releases them.
- R3: While sleeping, a low level on `wake_n` leaves sleep on the third clock edge after it is driven, because of the two-flop synchronizer. If the synchronized pin is already low when sleep is entered, sleep lasts exactly one cycle.
- R4: While sleeping, `rtc_evt` wakes the block on the next edge only when `rtc_wake_en` is high. With `rtc_wake_en` low it has no effect.
- R5: After wake, regulator recovery lasts REG_CYC cycles, clock startup lasts CLK_CYC cycles and reset processing lasts RST_CYC cycles, in that order.
- R6: While `lv_trip` is high during reset processing, that phase does not advance, so it lasts RST_CYC plus the number of cycles with `lv_trip` high.
- R7: During reset processing `mod_rst` equals the bitwise inverse of KEEP_MASK (bit i set resets register i). In every other phase it is zero.
- R8: `lvr_en` is 0 after the block reset and becomes 1 at the first wake from deep sleep.
- R9: `ifetch_en` is low from sleep entry through the end of reset processing. `pd_flag` becomes 1 when reset processing ends, and `ifetch_en` goes high at the same time.
- R10: In phase awaiting-acknowledge, `ack_wr` with `ack_data`=1 clears `pd_flag`, returns to run and makes the pins follow the live controls on the next clock.
- R11: An acknowledge write with `ack_data`=0 has no effect. An acknowledge write of 1 while `pd_flag` is clear has no effect, and the pins stay transparent.
- R12: `phase` encodes run=0, sleeping=1, regulator recovery=2, clock startup=3, reset=4, awaiting acknowledge=5. The synchronous `rst` returns the block to run with the flag, `lvr_en` and `mod_rst` at zero and the pins transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | CPU stop request |
| deep_sel | input | 1 | Deep-sleep mode select |
| wake_n | input | 1 | Asynchronous active-low wake pin |
| rtc_evt | input | 1 | Real-time counter event |
| rtc_wake_en | input | 1 | Enables wake by the counter event |
| lv_trip | input | 1 | Supply below low-voltage trip point |
| ack_wr | input | 1 | Write strobe of the acknowledge bit |
| ack_data | input | 1 | Value written to the acknowledge bit |
| live_out | input | NPIN | Live pin output values |
| live_dir | input | NPIN | Live pin directions |
| live_pull | input | NPIN | Live pin pull enables |
| pin_out | output | NPIN | Output values driven to the pads |
| pin_dir | output | NPIN | Directions driven to the pads |
| pin_pull | output | NPIN | Pull enables driven to the pads |
| core_pwr_dn | output | 1 | Core domain power-down request |
| ifetch_en | output | 1 | Instruction fetch allowed |
| pd_flag | output | 1 | Sticky power-down flag |
| lvr_en | output | 1 | Low-voltage reset function enabled |
| mod_rst | output | NREG | Per-register wake reset |
| phase | output | 3 | Current phase code |

## Verification
The bench builds the block with REG_CYC=3, CLK_CYC=4, RST_CYC=2, four pins and six registers with KEEP_MASK 6'b110001. With these short phases, many complete sleep and wake rounds fit in a short run. The rounds sweep the three wake paths (pin, enabled counter event, pin already low at entry), zero to three cycles of low-voltage hold, and a fresh pin pattern for each round. Phase lengths, the reset vector and the captured pins are computed arithmetically from these parameters.

// File: rtl/dsleep_pkg.sv
package dsleep_pkg;
  typedef enum logic [2:0] {
    PH_RUN   = 3'd0,
    PH_SLEEP = 3'd1,
    PH_REGU  = 3'd2,
    PH_CLKS  = 3'd3,
    PH_RSTP  = 3'd4,
    PH_WACK  = 3'd5
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/dsleep_sync.sv
module dsleep_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/dsleep_seq.sv
module dsleep_seq
  import dsleep_pkg::*;
#(
  parameter int REG_CYC = 16,
  parameter int CLK_CYC = 32,
  parameter int RST_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       deep_sel,
  input  logic       wake_low,
  input  logic       rtc_evt,
  input  logic       rtc_wake_en,
  input  logic       lv_trip,
  input  logic       ack_wr,
  input  logic       ack_data,
  output logic [2:0] phase_o,
  output logic       capture,
  output logic       release_o,
  output logic       pd_flag,
  output logic       lvr_en
);
  localparam int MAXC = max3(REG_CYC, CLK_CYC, RST_CYC);
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] REG_LAST = CW'(REG_CYC - 1);
  localparam logic [CW-1:0] CLK_LAST = CW'(CLK_CYC - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);

  phase_e        state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          wake_any;
  logic          rst_done;

  assign wake_any  = wake_low | (rtc_evt & rtc_wake_en);
  assign capture   = (state == PH_RUN) & stop_req & deep_sel;
  assign release_o = (state == PH_WACK) & ack_wr & ack_data;
  assign rst_done  = (state == PH_RSTP) & !lv_trip & (cnt == RST_LAST);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      PH_RUN:   if (capture) state_n = PH_SLEEP;
      PH_SLEEP: if (wake_any) begin state_n = PH_REGU; cnt_n = '0; end
      PH_REGU: begin
        if (cnt == REG_LAST) begin state_n = PH_CLKS; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      PH_CLKS: begin
        if (cnt == CLK_LAST) begin state_n = PH_RSTP; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      PH_RSTP: begin
        if (rst_done) begin state_n = PH_WACK; cnt_n = '0; end
        else if (!lv_trip) cnt_n = cnt + 1'b1;
      end
      PH_WACK:  if (release_o) state_n = PH_RUN;
      default:  state_n = PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PH_RUN;
      cnt     <= '0;
      pd_flag <= 1'b0;
      lvr_en  <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      if (rst_done)                      pd_flag <= 1'b1;
      else if (release_o)                pd_flag <= 1'b0;
      if (state == PH_SLEEP && wake_any) lvr_en  <= 1'b1;
    end
  end

  assign phase_o = state;

  // R1
  entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_RUN && stop_req && deep_sel) |=> (state == PH_SLEEP));

  // R3
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_SLEEP && wake_low) |=> (state == PH_REGU));

  // R4
  rtc_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_SLEEP && !wake_low && !(rtc_evt && rtc_wake_en)) |=> (state == PH_SLEEP));

  // R6
  lvhold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_RSTP && lv_trip) |=> (state == PH_RSTP));

  // R9
  flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_flag) |-> (state == PH_WACK && $past(state) == PH_RSTP));

  // R11
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PH_WACK && !(ack_wr && ack_data)) |=> (state == PH_WACK && pd_flag));
endmodule

// File: rtl/dsleep_retain.sv
module dsleep_retain #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         release_i,
  input  logic [W-1:0] live,
  output logic [W-1:0] pins,
  output logic         hold
);
  logic [W-1:0] kept;

  always_ff @(posedge clk) begin
    if (rst)            hold <= 1'b0;
    else if (capture)   hold <= 1'b1;
    else if (release_i) hold <= 1'b0;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)          kept[g] <= 1'b0;
      else if (capture) kept[g] <= live[g];
    end
    assign pins[g] = hold ? kept[g] : live[g];
  end

  // R2
  pinhold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && $past(hold)) |-> (pins == $past(pins)));
endmodule

// File: rtl/dsleep_ctrl.sv
module dsleep_ctrl
  import dsleep_pkg::*;
#(
  parameter int              NPIN      = 8,
  parameter int              NREG      = 6,
  parameter logic [NREG-1:0] KEEP_MASK = 6'b110001,
  parameter int              REG_CYC   = 16,
  parameter int              CLK_CYC   = 32,
  parameter int              RST_CYC   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stop_req,
  input  logic            deep_sel,
  input  logic            wake_n,
  input  logic            rtc_evt,
  input  logic            rtc_wake_en,
  input  logic            lv_trip,
  input  logic            ack_wr,
  input  logic            ack_data,
  input  logic [NPIN-1:0] live_out,
  input  logic [NPIN-1:0] live_dir,
  input  logic [NPIN-1:0] live_pull,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_dir,
  output logic [NPIN-1:0] pin_pull,
  output logic            core_pwr_dn,
  output logic            ifetch_en,
  output logic            pd_flag,
  output logic            lvr_en,
  output logic [NREG-1:0] mod_rst,
  output logic [2:0]      phase
);
  localparam int PW = 3 * NPIN;

  logic          wake_s;
  logic          capture, release_w, hold;
  logic [PW-1:0] live_bus, pin_bus;

  dsleep_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_async(wake_n), .d_sync(wake_s)
  );

  dsleep_seq #(.REG_CYC(REG_CYC), .CLK_CYC(CLK_CYC), .RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst(rst), .stop_req(stop_req), .deep_sel(deep_sel),
    .wake_low(!wake_s), .rtc_evt(rtc_evt), .rtc_wake_en(rtc_wake_en),
    .lv_trip(lv_trip), .ack_wr(ack_wr), .ack_data(ack_data),
    .phase_o(phase), .capture(capture), .release_o(release_w),
    .pd_flag(pd_flag), .lvr_en(lvr_en)
  );

  assign live_bus = {live_pull, live_dir, live_out};

  dsleep_retain #(.W(PW)) u_ret (
    .clk(clk), .rst(rst), .capture(capture), .release_i(release_w),
    .live(live_bus), .pins(pin_bus), .hold(hold)
  );

  assign {pin_pull, pin_dir, pin_out} = pin_bus;

  assign core_pwr_dn = (phase == PH_SLEEP);
  assign ifetch_en   = (phase == PH_RUN) || (phase == PH_WACK);
  assign mod_rst     = (phase == PH_RSTP) ? ~KEEP_MASK : '0;

  // R7
  survive_chk: assert property (@(posedge clk) disable iff (rst)
    ((mod_rst & KEEP_MASK) == '0));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !$past(hold) && $past(phase) == PH_WACK) |-> 1'b0);

  // R9
  fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (core_pwr_dn) |-> (!ifetch_en && hold));
endmodule

// File: tb/sim_dsleep_ctrl.sv
`timescale 1ns/1ps
module sim_dsleep_ctrl;
  localparam int NPIN = 4, NREG = 6;
  localparam logic [NREG-1:0] KEEP = 6'b110001;
  localparam int RC = 3, CC = 4, TC = 2;

  logic clk = 0, rst = 1;
  logic stop_req = 0, deep_sel = 0, wake_n = 1, rtc_evt = 0, rtc_wake_en = 0;
  logic lv_trip = 0, ack_wr = 0, ack_data = 0;
  logic [NPIN-1:0] live_out = 0, live_dir = 0, live_pull = 0;
  logic [NPIN-1:0] pin_out, pin_dir, pin_pull;
  logic core_pwr_dn, ifetch_en, pd_flag, lvr_en;
  logic [NREG-1:0] mod_rst;
  logic [2:0] phase;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  dsleep_ctrl #(.NPIN(NPIN), .NREG(NREG), .KEEP_MASK(KEEP),
                .REG_CYC(RC), .CLK_CYC(CC), .RST_CYC(TC)) u0 (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int pins();
    return int'({pin_pull, pin_dir, pin_out});
  endfunction

  task automatic set_live(logic [11:0] v);
    {live_pull, live_dir, live_out} = v;
  endtask

  task automatic measure(int ph, output int n);
    n = 0;
    while (phase == 3'(ph) && n < 100) begin n++; step(); end
  endtask

  // src: 0 wake pin, 1 enabled counter event, 2 pin already low at entry
  task automatic round(int src, int lvx, logic [11:0] a, logic [11:0] b);
    int n, bad;
    set_live(a);
    if (src == 2) begin
      wake_n = 0; step(); step(); step();
      chk("R1 low pin ignored in run", phase, 0);
    end
    stop_req = 1; deep_sel = 1; step(); stop_req = 0;
    chk("R1 enter sleep", phase, 1);
    chk("R1 power down", core_pwr_dn, 1);
    chk("R9 fetch off", ifetch_en, 0);
    chk("R2 captured", pins(), a);
    set_live(b);
    if (src == 2) begin
      step();
      chk("R3 immediate exit", phase, 2);
      wake_n = 1;
    end else begin
      rtc_evt = 1; rtc_wake_en = 0;
      for (int i = 0; i < 3; i++) begin
        step();
        chk("R4 disabled event ignored", phase, 1);
      end
      rtc_evt = 0;
      chk("R2 held in sleep", pins(), a);
      if (src == 0) begin
        wake_n = 0; step(); step();
        chk("R3 sync delay", phase, 1);
        step();
        chk("R3 pin wake", phase, 2);
        wake_n = 1;
      end else begin
        rtc_evt = 1; rtc_wake_en = 1; step();
        chk("R4 enabled event wake", phase, 2);
        rtc_evt = 0; rtc_wake_en = 0;
      end
    end
    chk("R8 lvr enabled", lvr_en, 1);
    measure(2, n); chk("R5 regulator len", n, RC);
    chk("R5 then clock", phase, 3);
    measure(3, n); chk("R5 clock len", n, CC);
    chk("R5 then reset", phase, 4);
    n = 0; bad = 0;
    while (phase == 3'd4 && n < 100) begin
      if (mod_rst != ~KEEP) bad++;
      if (pd_flag != 0) bad++;
      lv_trip = (n < lvx);
      n++; step();
    end
    lv_trip = 0;
    chk("R6 reset len", n, TC + lvx);
    chk("R7 reset vector", bad, 0);
    chk("R9 await", phase, 5);
    chk("R9 flag", pd_flag, 1);
    chk("R9 fetch on", ifetch_en, 1);
    chk("R7 vector idle", mod_rst, 0);
    chk("R2 held to ack", pins(), a);
    ack_wr = 1; ack_data = 0; step(); ack_wr = 0;
    chk("R11 ack0 phase", phase, 5);
    chk("R11 ack0 flag", pd_flag, 1);
    chk("R11 ack0 pins", pins(), a);
    ack_wr = 1; ack_data = 1; step(); ack_wr = 0;
    chk("R10 run", phase, 0);
    chk("R10 flag clear", pd_flag, 0);
    chk("R10 pins live", pins(), b);
    ack_wr = 1; ack_data = 1; step(); ack_wr = 0;
    chk("R11 ack1 idle phase", phase, 0);
    chk("R11 ack1 idle flag", pd_flag, 0);
    set_live(a); #1;
    chk("R11 transparent", pins(), a);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst = 0;
    chk("R12 reset phase", phase, 0);
    chk("R12 reset flag", pd_flag, 0);
    chk("R8 reset lvr", lvr_en, 0);
    chk("R12 reset vector", mod_rst, 0);
    chk("R9 run fetch", ifetch_en, 1);
    chk("R1 no power down", core_pwr_dn, 0);
    set_live(12'h5a3); #1;
    chk("R12 pins live", pins(), 12'h5a3);
    stop_req = 1; deep_sel = 0; step(); stop_req = 0;
    chk("R1 mode0 ignored", phase, 0);
    for (int p = 0; p < 12; p++) begin
      logic [11:0] a, b;
      a = 12'((p * 653 + 17) & 12'hfff);
      b = ~a ^ 12'(p);
      round(p % 3, p % 4, a, b);
    end
    rst = 1; step(); rst = 0;
    chk("R8 lvr cleared by reset", lvr_en, 0);
    chk("R12 phase after reset", phase, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule